// File: doc/BRIEF.md
# Interlaken Lane Metaframe Synchronizer

This block is the per-lane receive stage that sits after 64B/67B block alignment. Each cycle it may take one aligned lane word: a control/data indicator and 64 payload bits. It searches that stream for synchronization control words that recur at a fixed metaframe period. Four such words in a row at the expected spacing declare metaframe lock. Four missed or corrupt ones in a row drop lock again. Every accepted word goes into a small receive FIFO, and the downstream MAC drains it through a valid/ready stream.

The input side carries a ready signal, but the lane cannot be stalled. `in_ready` only reports that the block has left reset. Once it is high, every valid word is offered to the FIFO, and a word that finds the FIFO full is dropped. The output side obeys normal back-pressure. A word is presented while the FIFO holds data, leaves only on a cycle with both `out_valid` and `out_ready` high, and stays unchanged while the reader stalls.

The status pins are plain levels:
- ready;
- metaframe lock;
- a combined block/frame lock, which also requires data in the FIFO;
- a sticky flag for the first sync word seen at the read side;
- a sticky overflow flag;
- a partially-empty flag that tells the MAC when to start reading;
- a registered copy of an external CRC32 error strobe.

Top module: `ilk_lane_mfsync`

## Requirements
- R1: `rx_ready` is low while `rst_n` is low and rises at the first clock edge after reset release, then stays high; `out_valid` is low whenever `rx_ready` is low.
- R2: A sync word is a word with `in_ctrl`=1 and `in_data[63:58]` = 6'h1E; a word with that field but `in_ctrl`=0, or with `in_ctrl`=1 and another field value, never counts as sync.
- R3: Out of lock, the first sync word starts a candidate; lock (`mf_lock`=1) is declared on the edge that accepts the 4th sync word, each found exactly MF_LEN accepted words after the previous one; a non-sync word at an expected slot discards the candidate. Cycles without `in_valid` do not advance the position.
- R4: In lock, 4 consecutive expected slots without a sync word clear `mf_lock`; a sync word at an expected slot resets the miss count.
- R5: `blk_frm_lock` is registered: at each edge it takes the lock state after that edge AND'ed with "FIFO was non-empty before that edge", so it falls one cycle after the FIFO empties.
- R6: An empty FIFO never clears `mf_lock` or `sync_seen`.
- R7: `sync_seen` is set when a word that matches the R2 pattern is read from the FIFO, stays set, and is cleared (taking priority) on the edge where lock is lost.
- R8: The FIFO returns accepted words in order; `out_valid` is high when it holds data; a word leaves on `out_valid && out_ready`, and `out_ctrl`/`out_data` hold while stalled.
- R9: A write that arrives while the FIFO holds DEPTH words is dropped (even if a read happens in the same cycle) and sets `fifo_ovf`, which stays high until reset.
- R10: `part_empty` is high exactly while the FIFO holds fewer than PE_THRESH words.
- R11: `crc_err` equals `crc_err_in` delayed by one clock.
- R12: `in_ready` follows `rx_ready`; a word offered while `in_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lane word present |
| in_ready | output | 1 | Block accepts lane words (no stall) |
| in_ctrl | input | 1 | Control/data indicator of the lane word |
| in_data | input | 64 | Lane word payload |
| crc_err_in | input | 1 | CRC32 error strobe from the lane checker |
| out_valid | output | 1 | FIFO head word available |
| out_ready | input | 1 | Reader takes the head word |
| out_ctrl | output | 1 | Control indicator of the head word |
| out_data | output | 64 | Payload of the head word |
| rx_ready | output | 1 | Receive side out of reset |
| blk_frm_lock | output | 1 | Combined block/frame lock |
| mf_lock | output | 1 | Metaframe lock |
| sync_seen | output | 1 | Sticky: a sync word has been read out |
| fifo_ovf | output | 1 | Sticky FIFO overflow |
| part_empty | output | 1 | FIFO fill below threshold |
| crc_err | output | 1 | Registered CRC32 error flag |

## Verification
The hardest state to reach is an empty FIFO while the framer stays locked, because a reader that keeps pace normally leaves one word in flight. The bench locks the lane with a continuous reader, then stops sending words. The FIFO then drains while `mf_lock` and `sync_seen` must hold. Loss of lock is reached in two steps: first three corrupt sync slots followed by a good one, which must keep lock, then four corrupt slots in a row. Overflow is forced by stalling the reader while a burst longer than DEPTH arrives. The final drain then shows that the dropped words never appear.

// File: rtl/ilk_mfs_pkg.sv
package ilk_mfs_pkg;
  typedef enum logic [1:0] {
    FR_HUNT   = 2'd0,
    FR_VERIFY = 2'd1,
    FR_LOCKED = 2'd2
  } fr_state_e;

  localparam int unsigned TYPE_W = 6;
  localparam logic [TYPE_W-1:0] SYNC_TYPE = 6'h1E;

  function automatic logic sync_match(input logic ctrl, input logic [TYPE_W-1:0] tfield);
    return ctrl && (tfield == SYNC_TYPE);
  endfunction
endpackage

// File: rtl/ilk_mfs_framer.sv
module ilk_mfs_framer
  import ilk_mfs_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned MF_LEN   = 16,
  parameter int unsigned GOOD_CNT = 4,
  parameter int unsigned BAD_CNT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              ctrl,
  input  logic [DATA_W-1:0] data,
  output logic              is_sync,
  output logic              lock_q,
  output logic              lock_nxt,
  output logic              loss
);
  localparam int unsigned POS_W  = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
  localparam int unsigned HIT_W  = $clog2(GOOD_CNT + 1);
  localparam int unsigned MISS_W = $clog2(BAD_CNT + 1);
  localparam logic [POS_W-1:0]  POS_LAST = POS_W'(MF_LEN - 1);
  localparam logic [HIT_W-1:0]  HIT_GOAL = HIT_W'(GOOD_CNT);
  localparam logic [MISS_W-1:0] MISS_LIM = MISS_W'(BAD_CNT);

  fr_state_e         st_q, st_n;
  logic [POS_W-1:0]  pos_q, pos_n, pos_inc;
  logic [HIT_W-1:0]  hits_q, hits_n;
  logic [MISS_W-1:0] miss_q, miss_n;
  logic              at_slot;

  assign is_sync = sync_match(ctrl, data[DATA_W-1 -: TYPE_W]);
  assign at_slot = (pos_q == '0);
  assign pos_inc = (pos_q == POS_LAST) ? '0 : pos_q + POS_W'(1);

  always_comb begin
    st_n   = st_q;
    pos_n  = pos_q;
    hits_n = hits_q;
    miss_n = miss_q;
    loss   = 1'b0;
    if (wr) begin
      unique case (st_q)
        FR_HUNT: begin
          if (is_sync) begin
            st_n   = FR_VERIFY;
            hits_n = HIT_W'(1);
            pos_n  = POS_W'(1);
          end
        end
        FR_VERIFY: begin
          pos_n = pos_inc;
          if (at_slot) begin
            if (is_sync) begin
              hits_n = hits_q + HIT_W'(1);
              if (hits_q + HIT_W'(1) == HIT_GOAL) begin
                st_n   = FR_LOCKED;
                miss_n = '0;
              end
            end else begin
              st_n   = FR_HUNT;
              hits_n = '0;
            end
          end
        end
        FR_LOCKED: begin
          pos_n = pos_inc;
          if (at_slot) begin
            if (is_sync) begin
              miss_n = '0;
            end else begin
              miss_n = miss_q + MISS_W'(1);
              if (miss_q + MISS_W'(1) == MISS_LIM) begin
                st_n   = FR_HUNT;
                hits_n = '0;
                loss   = 1'b1;
              end
            end
          end
        end
        default: st_n = FR_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_HUNT;
      pos_q  <= '0;
      hits_q <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_n;
      pos_q  <= pos_n;
      hits_q <= hits_n;
      miss_q <= miss_n;
    end
  end

  assign lock_q   = (st_q == FR_LOCKED);
  assign lock_nxt = (st_n == FR_LOCKED);
endmodule

// File: rtl/ilk_mfs_fifo.sv
module ilk_mfs_fifo #(
  parameter int unsigned W         = 66,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PE_THRESH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         rd_en,
  output logic [W-1:0] rd_word,
  output logic         nonempty,
  output logic         part_empty,
  output logic         ovf
);
  localparam int unsigned PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_PE   = CNT_W'(PE_THRESH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, wr_ok;

  assign full  = (cnt_q == CNT_FULL);
  assign wr_ok = wr_en && !full;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_ok) wp_q <= wp_q + PTR_W'(1);
      if (rd_en) rp_q <= rp_q + PTR_W'(1);
      unique case ({wr_ok, rd_en})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  assign rd_word    = mem[rp_q];
  assign nonempty   = (cnt_q != '0);
  assign part_empty = (cnt_q < CNT_PE);
endmodule

// File: rtl/ilk_mfs_status.sv
module ilk_mfs_status (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_nxt,
  input  logic loss,
  input  logic fifo_nonempty,
  input  logic rd_fire,
  input  logic rd_is_sync,
  input  logic crc_in,
  output logic rdy,
  output logic bfl,
  output logic seen,
  output logic crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      bfl  <= 1'b0;
      seen <= 1'b0;
      crc  <= 1'b0;
    end else begin
      rdy <= 1'b1;
      bfl <= lock_nxt && fifo_nonempty;
      crc <= crc_in;
      if (loss) seen <= 1'b0;
      else if (rd_fire && rd_is_sync) seen <= 1'b1;
    end
  end
endmodule

// File: rtl/ilk_lane_mfsync.sv
module ilk_lane_mfsync
  import ilk_mfs_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned MF_LEN    = 16,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PE_THRESH = 4,
  parameter int unsigned GOOD_CNT  = 4,
  parameter int unsigned BAD_CNT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ctrl,
  input  logic [DATA_W-1:0] in_data,
  input  logic              crc_err_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ctrl,
  output logic [DATA_W-1:0] out_data,
  output logic              rx_ready,
  output logic              blk_frm_lock,
  output logic              mf_lock,
  output logic              sync_seen,
  output logic              fifo_ovf,
  output logic              part_empty,
  output logic              crc_err
);
  localparam int unsigned ENT_W = DATA_W + 2;

  logic             wr, rd, f_nonempty, is_sync, lock_nxt, loss;
  logic [ENT_W-1:0] wr_ent, rd_ent;

  assign in_ready = rx_ready;
  assign wr       = in_valid && rx_ready;
  assign wr_ent   = {is_sync, in_ctrl, in_data};

  ilk_mfs_framer #(
    .DATA_W(DATA_W), .MF_LEN(MF_LEN), .GOOD_CNT(GOOD_CNT), .BAD_CNT(BAD_CNT)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ctrl(in_ctrl), .data(in_data),
    .is_sync(is_sync), .lock_q(mf_lock), .lock_nxt(lock_nxt), .loss(loss)
  );

  ilk_mfs_fifo #(
    .W(ENT_W), .DEPTH(DEPTH), .PE_THRESH(PE_THRESH)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_word(wr_ent), .rd_en(rd),
    .rd_word(rd_ent), .nonempty(f_nonempty), .part_empty(part_empty), .ovf(fifo_ovf)
  );

  assign out_valid = f_nonempty && rx_ready;
  assign rd        = out_valid && out_ready;
  assign out_ctrl  = rd_ent[DATA_W];
  assign out_data  = rd_ent[DATA_W-1:0];

  ilk_mfs_status u_status (
    .clk(clk), .rst_n(rst_n), .lock_nxt(lock_nxt), .loss(loss),
    .fifo_nonempty(f_nonempty), .rd_fire(rd), .rd_is_sync(rd_ent[ENT_W-1]),
    .crc_in(crc_err_in), .rdy(rx_ready), .bfl(blk_frm_lock), .seen(sync_seen),
    .crc(crc_err)
  );
endmodule

// File: rtl/ilk_mfs_checker.sv
module ilk_mfs_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              blk_frm_lock,
  input logic              mf_lock,
  input logic              sync_seen,
  input logic              fifo_ovf,
  input logic              part_empty,
  input logic              crc_err_in,
  input logic              crc_err
);
  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> rx_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  // R5
  bfl_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_frm_lock |-> mf_lock);

  // R5
  bfl_empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !out_valid |=> !blk_frm_lock);

  // R7
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_seen |=> sync_seen || $fell(mf_lock));

  // R10
  pe_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !part_empty |-> out_valid);

  // R11
  crc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_in |=> crc_err);

  // R11
  crc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_err_in |=> !crc_err);
endmodule

bind ilk_lane_mfsync ilk_mfs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .blk_frm_lock(blk_frm_lock),
  .mf_lock(mf_lock), .sync_seen(sync_seen), .fifo_ovf(fifo_ovf),
  .part_empty(part_empty), .crc_err_in(crc_err_in), .crc_err(crc_err)
);

// File: tb/ilk_lane_mfsync_test.sv
module ilk_lane_mfsync_test;
  localparam int MFL = 8;
  localparam int DEP = 8;
  localparam int PET = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ctrl = 1'b0, crc_err_in = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic in_ready, out_valid, out_ctrl, rx_ready, blk_frm_lock, mf_lock;
  logic sync_seen, fifo_ovf, part_empty, crc_err;
  logic [63:0] out_data;

  always #10 clk = ~clk;

  ilk_lane_mfsync #(.DATA_W(64), .MF_LEN(MFL), .DEPTH(DEP), .PE_THRESH(PET)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctrl(in_ctrl), .in_data(in_data), .crc_err_in(crc_err_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
    .out_data(out_data), .rx_ready(rx_ready), .blk_frm_lock(blk_frm_lock),
    .mf_lock(mf_lock), .sync_seen(sync_seen), .fifo_ovf(fifo_ovf),
    .part_empty(part_empty), .crc_err(crc_err)
  );

  int checks = 0, failures = 0;
  bit cmp_en = 0, done = 0, rand_rd = 0, rand_crc = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [64:0] q[$];
  int  m_st, m_pos, m_hits, m_miss, cnt0;
  bit  m_rdy, m_bfl, m_seen, m_ovf, m_crc, m_loss, m_wr, m_rd, m_sy, lock_after;
  logic [64:0] head;

  function automatic bit is_sync_w(logic c, logic [63:0] d);
    return c && (d[63:58] == 6'h1E);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_st = 0; m_pos = 0; m_hits = 0; m_miss = 0;
      m_rdy = 0; m_bfl = 0; m_seen = 0; m_ovf = 0; m_crc = 0;
    end else begin
      cnt0 = q.size();
      m_wr = in_valid && m_rdy;
      m_rd = m_rdy && cnt0 > 0 && out_ready;
      m_loss = 0;
      if (m_wr) begin
        m_sy = is_sync_w(in_ctrl, in_data);
        if (m_st == 0) begin
          if (m_sy) begin m_st = 1; m_hits = 1; m_pos = 1; end
        end else if (m_st == 1) begin
          if (m_pos == 0) begin
            if (m_sy) begin
              m_hits++;
              if (m_hits == 4) begin m_st = 2; m_miss = 0; end
            end else begin m_st = 0; m_hits = 0; end
          end
          m_pos = (m_pos + 1) % MFL;
        end else begin
          if (m_pos == 0) begin
            if (m_sy) m_miss = 0;
            else begin
              m_miss++;
              if (m_miss == 4) begin m_st = 0; m_hits = 0; m_loss = 1; end
            end
          end
          m_pos = (m_pos + 1) % MFL;
        end
      end
      lock_after = (m_st == 2);
      if (m_rd) begin
        head = q.pop_front();
        if (is_sync_w(head[64], head[63:0])) m_seen = 1;
      end
      if (m_loss) m_seen = 0;
      if (m_wr) begin
        if (cnt0 == DEP) m_ovf = 1;
        else q.push_back({in_ctrl, in_data});
      end
      m_bfl = lock_after && (cnt0 != 0);
      m_crc = crc_err_in;
      m_rdy = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1 rx_ready", 64'(rx_ready), 64'(m_rdy));
      chk("R12 in_ready", 64'(in_ready), 64'(m_rdy));
      chk("R8 out_valid", 64'(out_valid), 64'(m_rdy && q.size() > 0));
      if (m_rdy && q.size() > 0) begin
        chk("R8 out_ctrl", 64'(out_ctrl), 64'(q[0][64]));
        chk("R8 out_data", out_data, q[0][63:0]);
      end
      chk("R3 mf_lock", 64'(mf_lock), 64'(m_st == 2));
      chk("R5 blk_frm_lock", 64'(blk_frm_lock), 64'(m_bfl));
      chk("R7 sync_seen", 64'(sync_seen), 64'(m_seen));
      chk("R9 fifo_ovf", 64'(fifo_ovf), 64'(m_ovf));
      chk("R10 part_empty", 64'(part_empty), 64'(q.size() < PET));
      chk("R11 crc_err", 64'(crc_err), 64'(m_crc));
    end
  end

  int serial = 0;

  task automatic put(logic c, logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = c; in_data = d;
    if (rand_rd) out_ready = 1'($urandom % 2);
    if (rand_crc) crc_err_in = (($urandom % 5) == 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (rand_rd) out_ready = 1'($urandom % 2);
      if (rand_crc) crc_err_in = 1'b0;
    end
  endtask

  // kind: 0 good sync, 1 ctrl word with wrong type, 2 sync type with ctrl=0
  task automatic send_mf(int kind, bit gaps);
    for (int j = 0; j < MFL; j++) begin
      serial++;
      if (j == 0) begin
        case (kind)
          0: put(1'b1, {6'h1E, 26'h0, 32'(serial)});
          1: put(1'b1, {6'h21, 26'h0, 32'(serial)});
          default: put(1'b0, {6'h1E, 26'h0, 32'(serial)});
        endcase
      end else begin
        put(1'b0, {6'h05, 26'h3A5, 32'(serial)});
      end
      if (gaps && ($urandom % 4) == 0) idle(1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 64'(rx_ready), 64'd0);
    in_valid = 1'b1; in_ctrl = 1'b1; in_data = {6'h1E, 58'h1};
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 word before ready ignored", 64'(out_valid), 64'd0);
    out_ready = 1'b1;
    // R2: sync type without ctrl never locks
    for (int k = 0; k < 5; k++) send_mf(2, 0);
    idle(1);
    chk("R2 ctrl=0 pattern not sync", 64'(mf_lock), 64'd0);
    // R3: four good metaframes lock
    for (int k = 0; k < 4; k++) send_mf(0, 0);
    idle(1);
    chk("R3 lock after four syncs", 64'(mf_lock), 64'd1);
    send_mf(0, 0);
    idle(4);
    chk("R5 combined lock drops when empty", 64'(blk_frm_lock), 64'd0);
    chk("R6 mf_lock kept through empty", 64'(mf_lock), 64'd1);
    chk("R6 sync_seen kept through empty", 64'(sync_seen), 64'd1);
    // R4: three misses then a good sync keeps lock
    for (int k = 0; k < 3; k++) send_mf(1, 0);
    send_mf(0, 0);
    idle(1);
    chk("R4 miss count reset by good sync", 64'(mf_lock), 64'd1);
    for (int k = 0; k < 4; k++) send_mf(1, 0);
    idle(1);
    chk("R4 lock lost after four misses", 64'(mf_lock), 64'd0);
    chk("R7 sync_seen cleared on loss", 64'(sync_seen), 64'd0);
    // R9/R10: overflow with stalled reader
    out_ready = 1'b0;
    idle(1);
    for (int k = 0; k < DEP + 4; k++) put(1'b0, 64'hC0DE_0000 + 64'(k));
    idle(1);
    chk("R9 overflow flagged", 64'(fifo_ovf), 64'd1);
    chk("R10 part_empty low when full", 64'(part_empty), 64'd0);
    out_ready = 1'b1;
    idle(DEP + 2);
    chk("R10 part_empty high when drained", 64'(part_empty), 64'd1);
    chk("R9 overflow sticky", 64'(fifo_ovf), 64'd1);
    // R11: single crc strobe
    @(negedge clk); crc_err_in = 1'b1;
    @(negedge clk); crc_err_in = 1'b0;
    chk("R11 crc strobe registered", 64'(crc_err), 64'd1);
    // mixed traffic: random reader, gaps, crc
    rand_rd = 1; rand_crc = 1;
    for (int k = 0; k < 8; k++) send_mf(0, 1);
    for (int k = 0; k < 4; k++) send_mf(1, 1);
    for (int k = 0; k < 6; k++) send_mf(0, 1);
    rand_rd = 0; rand_crc = 0;
    out_ready = 1'b1; crc_err_in = 1'b0;
    idle(DEP + 4);
    chk("R8 drained at end", 64'(out_valid), 64'd0);
    cmp_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule